// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Parallel Read-Out Driver

This block drives an 8-channel, 16-bit successive-approximation converter that samples all of its inputs at once and returns the results on a 16-bit parallel bus. The driver pulls the conversion-start line low, waits for the converter's busy line to fall, and then reads every channel in turn using the chip-select and read strobes. It hands each result on with a one-cycle valid strobe, and a sync flag marks the word for the first channel.

A small configuration register sets the static pins of the converter: the oversampling ratio, the input range, standby, and a timed reset pulse. A low pulse on a write strobe loads the register from a 16-bit input, and a one-cycle acknowledge confirms each load. Conversions run back to back for as long as the continuous-enable bit is set. When that bit is cleared, the frame in progress runs to its end and the driver then stays idle.

The sequencer has six states. S_IDLE goes to S_CONV when continuous mode is on. S_CONV goes to S_BUSY_WAIT once its low pulse is complete. S_BUSY_WAIT goes to S_BUSY_LOW when its cycle count expires. S_BUSY_LOW goes to S_RD_LO when busy is low. S_RD_LO goes to S_RD_HI after the strobe, or back to S_IDLE after the last channel. S_RD_HI goes to S_RD_LO once the gap between reads is over.

Top module: `sar_adc_drv`

## Requirements
- R1: While reset is asserted and just after it is released, conv_n, cs_n and rd_n are high; data_vld, sync, cfg_ack and adc_rst are low; os, range_sel and stdby are 0.
- R2: The write strobe cfg_wr_n is sampled on the clock. In the clock after a high-to-low transition is seen, the fields of cfg_din are on the pins and cfg_ack is high for exactly one cycle: os = bits 2:0, range_sel = bit 3, stdby = bit 4. Holding the strobe low longer gives no further acknowledge. Bits 15:7 are ignored.
- R3: A load with bit 5 set drives adc_rst high for exactly RST_LEN (4) cycles. Bit 5 is not kept in the register.
- R4: Each conversion starts with conv_n low for exactly CONV_LO (2) cycles. No conversion starts while bit 6 (continuous enable) is clear.
- R5: No read takes place until BUSY_WAIT cycles have passed after conv_n returns high and busy is low. cs_n and rd_n are never low while busy is high.
- R6: For each channel, rd_n is low for exactly RD_LO (3) cycles. Between channels it is high for exactly RD_HI (2) cycles. cs_n stays low across all 8 reads and goes high after the last one.
- R7: Each conversion gives exactly 8 data_vld pulses, each one cycle long. They come in channel order, and each word equals the bus value present in the last low cycle of rd_n.
- R8: sync is high only together with the data_vld of the first channel's word.
- R9: After a frame, a new conversion starts only if bit 6 is still set. Clearing it mid-frame lets that frame complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_n | input | 1 | Active-low configuration write strobe |
| cfg_din | input | 16 | Configuration word |
| adc_db | input | 16 | Converter parallel data bus |
| adc_busy | input | 1 | Converter busy, high during conversion |
| data_out | output | 16 | Last captured result |
| data_vld | output | 1 | One-cycle strobe for a new data_out word |
| sync | output | 1 | Marks the first channel's word |
| cfg_ack | output | 1 | One-cycle acknowledge of a configuration load |
| conv_n | output | 1 | Active-low conversion start |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| os | output | 3 | Oversampling ratio select |
| range_sel | output | 1 | High selects the ±10 V range, low selects ±5 V |
| stdby | output | 1 | Standby pin |
| adc_rst | output | 1 | Active-high converter reset pulse |

## Verification
The bench uses three busy lengths: shorter than the busy wait, slightly longer, and far longer. A driver that samples busy too early or ignores it would strobe rd_n while busy is still high. Pulse widths are measured for every conv_n, rd_n and inter-read gap, so an off-by-one in any counter shows up as a wrong run length. The check on data words compares each channel tag with its position and each frame tag with the frame count, which catches a capture on the wrong cycle, a missing word or a misplaced sync. Clearing continuous mode mid-frame has to yield a complete final frame and then silence. Holding the write strobe low has to yield a single acknowledge.

// File: rtl/sar_drv_pkg.sv
package sar_drv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CONV,
        S_BUSY_WAIT,
        S_BUSY_LOW,
        S_RD_LO,
        S_RD_HI
    } drv_state_t;

    // Stored configuration fields (reset request is a trigger, not stored)
    typedef struct packed {
        logic       cont;
        logic       stdby;
        logic       range_sel;
        logic [2:0] os;
    } cfg_t;

    localparam int CFG_OS_LSB    = 0;
    localparam int CFG_RANGE_BIT = 3;
    localparam int CFG_STDBY_BIT = 4;
    localparam int CFG_RST_BIT   = 5;
    localparam int CFG_CONT_BIT  = 6;

endpackage

// File: rtl/sar_cfg_reg.sv
module sar_cfg_reg
    import sar_drv_pkg::*;
#(
    parameter int DW      = 16,
    parameter int RST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic [DW-1:0] din,
    output cfg_t          cfg,
    output logic          ack,
    output logic          adc_rst
);
    localparam int RW = $clog2(RST_LEN + 1);

    logic          wr_q;
    logic          load;
    logic [RW-1:0] rst_cnt;
    logic          unused_din;

    assign load       = wr_q & ~wr_n;
    assign unused_din = ^din[DW-1:CFG_CONT_BIT+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b1;
            ack     <= 1'b0;
            cfg     <= '0;
            rst_cnt <= '0;
        end else begin
            wr_q <= wr_n;
            ack  <= load;
            if (load) begin
                cfg.os        <= din[CFG_OS_LSB +: 3];
                cfg.range_sel <= din[CFG_RANGE_BIT];
                cfg.stdby     <= din[CFG_STDBY_BIT];
                cfg.cont      <= din[CFG_CONT_BIT];
            end
            if (load && din[CFG_RST_BIT])
                rst_cnt <= RW'(RST_LEN);
            else if (rst_cnt != '0)
                rst_cnt <= rst_cnt - 1'b1;
        end
    end

    assign adc_rst = (rst_cnt != '0);

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_drv_pkg::*;
#(
    parameter int DW        = 16,
    parameter int NCH       = 8,
    parameter int CONV_LO   = 2,
    parameter int BUSY_WAIT = 4,
    parameter int RD_LO     = 3,
    parameter int RD_HI     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cont_en,
    input  logic          busy,
    input  logic [DW-1:0] adc_db,
    output logic          conv_n,
    output logic          cs_n,
    output logic          rd_n,
    output logic [DW-1:0] data_out,
    output logic          data_vld,
    output logic          sync
);
    localparam int M1   = (CONV_LO > BUSY_WAIT) ? CONV_LO : BUSY_WAIT;
    localparam int M2   = (RD_LO > RD_HI) ? RD_LO : RD_HI;
    localparam int TMAX = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;

    drv_state_t     state, state_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic [CHW-1:0] ch, ch_n;
    logic           capture;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            ch    <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            ch    <= ch_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt + 1'b1;
        ch_n    = ch;
        capture = 1'b0;
        unique case (state)
            S_IDLE: begin
                cnt_n = '0;
                if (cont_en) state_n = S_CONV;
            end
            S_CONV: if (cnt == CW'(CONV_LO - 1)) begin
                state_n = S_BUSY_WAIT;
                cnt_n   = '0;
            end
            S_BUSY_WAIT: if (cnt == CW'(BUSY_WAIT - 1)) begin
                state_n = S_BUSY_LOW;
                cnt_n   = '0;
            end
            S_BUSY_LOW: begin
                cnt_n = '0;
                ch_n  = '0;
                if (!busy) state_n = S_RD_LO;
            end
            S_RD_LO: if (cnt == CW'(RD_LO - 1)) begin
                capture = 1'b1;
                cnt_n   = '0;
                state_n = (ch == CHW'(NCH - 1)) ? S_IDLE : S_RD_HI;
            end
            S_RD_HI: if (cnt == CW'(RD_HI - 1)) begin
                cnt_n   = '0;
                ch_n    = ch + 1'b1;
                state_n = S_RD_LO;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // pin outputs
    always_comb begin
        conv_n = (state != S_CONV);
        cs_n   = !((state == S_RD_LO) || (state == S_RD_HI));
        rd_n   = (state != S_RD_LO);
    end

    // result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_vld <= 1'b0;
            sync     <= 1'b0;
        end else begin
            data_vld <= capture;
            sync     <= capture && (ch == '0);
            if (capture) data_out <= adc_db;
        end
    end

endmodule

// File: rtl/sar_adc_drv.sv
module sar_adc_drv
    import sar_drv_pkg::*;
#(
    parameter int DW        = 16,
    parameter int NCH       = 8,
    parameter int CONV_LO   = 2,
    parameter int BUSY_WAIT = 4,
    parameter int RD_LO     = 3,
    parameter int RD_HI     = 2,
    parameter int RST_LEN   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_n,
    input  logic [15:0]   cfg_din,
    input  logic [DW-1:0] adc_db,
    input  logic          adc_busy,
    output logic [DW-1:0] data_out,
    output logic          data_vld,
    output logic          sync,
    output logic          cfg_ack,
    output logic          conv_n,
    output logic          cs_n,
    output logic          rd_n,
    output logic [2:0]    os,
    output logic          range_sel,
    output logic          stdby,
    output logic          adc_rst
);
    cfg_t cfg;

    sar_cfg_reg #(.DW(16), .RST_LEN(RST_LEN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_n    (cfg_wr_n),
        .din     (cfg_din),
        .cfg     (cfg),
        .ack     (cfg_ack),
        .adc_rst (adc_rst)
    );

    sar_seq_fsm #(
        .DW(DW), .NCH(NCH), .CONV_LO(CONV_LO), .BUSY_WAIT(BUSY_WAIT),
        .RD_LO(RD_LO), .RD_HI(RD_HI)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cont_en  (cfg.cont),
        .busy     (adc_busy),
        .adc_db   (adc_db),
        .conv_n   (conv_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .data_out (data_out),
        .data_vld (data_vld),
        .sync     (sync)
    );

    assign os        = cfg.os;
    assign range_sel = cfg.range_sel;
    assign stdby     = cfg.stdby;

endmodule

// File: rtl/sar_adc_drv_chk.sv
module sar_adc_drv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       data_vld,
    input logic       sync,
    input logic       cfg_ack,
    input logic [2:0] os,
    input logic       range_sel,
    input logic       stdby
);
    p_rd_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    p_conv_outside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_n |-> cs_n);

    p_conv_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n) |=> !conv_n);

    p_sync_with_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> data_vld);

    p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |=> !data_vld);

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);

    p_pins_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ack |-> $stable({os, range_sel, stdby}));

endmodule

bind sar_adc_drv sar_adc_drv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_n    (conv_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .data_vld  (data_vld),
    .sync      (sync),
    .cfg_ack   (cfg_ack),
    .os        (os),
    .range_sel (range_sel),
    .stdby     (stdby)
);

// File: tb/tb_sar_adc_drv.sv
`timescale 1ns/1ps
module tb_sar_adc_drv;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_n;
    logic [15:0] cfg_din;
    logic [15:0] adc_db;
    logic        adc_busy;
    logic [15:0] data_out;
    logic        data_vld, sync, cfg_ack, conv_n, cs_n, rd_n;
    logic [2:0]  os;
    logic        range_sel, stdby, adc_rst;

    always #4 clk = ~clk;

    sar_adc_drv dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_n(cfg_wr_n), .cfg_din(cfg_din),
        .adc_db(adc_db), .adc_busy(adc_busy), .data_out(data_out),
        .data_vld(data_vld), .sync(sync), .cfg_ack(cfg_ack),
        .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n), .os(os),
        .range_sel(range_sel), .stdby(stdby), .adc_rst(adc_rst)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // converter model and pin monitor
    int busy_len = 6;
    int busy_tmr, frame, rd_idx, conv_falls;
    int conv_run, last_conv_run, rd_run, rd_min, rd_max;
    int gap_run, gap_min, busy_viol, rst_run, last_rst_run;
    int nvld, ack_cnt;
    logic [15:0] got_data [64];
    logic        got_sync [64];
    int          got_frame[64];
    bit conv_p, rd_p, clr;

    assign adc_db = {frame[7:0], 5'b10100, rd_idx[2:0]};

    always @(posedge clk) begin
        conv_p <= conv_n;
        rd_p   <= rd_n;
        if (!rst_n) begin
            adc_busy <= 1'b0;
            busy_tmr <= 0;
            frame    <= 0;
            rd_idx   <= 0;
        end else if (conv_p && !conv_n) begin
            frame    <= frame + 1;
            rd_idx   <= 0;
            adc_busy <= 1'b1;
            busy_tmr <= busy_len;
        end else begin
            if (busy_tmr > 0) begin
                busy_tmr <= busy_tmr - 1;
                if (busy_tmr == 1) adc_busy <= 1'b0;
            end
            if (!rd_p && rd_n) rd_idx <= rd_idx + 1;
        end

        if (clr) begin
            conv_falls <= 0; conv_run <= 0; last_conv_run <= 0;
            rd_run <= 0; rd_min <= 999; rd_max <= 0;
            gap_run <= 0; gap_min <= 999; busy_viol <= 0;
            rst_run <= 0; last_rst_run <= 0; nvld <= 0; ack_cnt <= 0;
        end else begin
            if (conv_p && !conv_n) conv_falls <= conv_falls + 1;
            if (!conv_n) conv_run <= conv_run + 1;
            else if (conv_run != 0) begin last_conv_run <= conv_run; conv_run <= 0; end
            if (!rd_n) rd_run <= rd_run + 1;
            else if (rd_run != 0) begin
                if (rd_run < rd_min) rd_min <= rd_run;
                if (rd_run > rd_max) rd_max <= rd_run;
                rd_run <= 0;
            end
            if (!cs_n && rd_n) gap_run <= gap_run + 1;
            else if (gap_run != 0) begin
                if (!rd_n && gap_run < gap_min) gap_min <= gap_run;
                gap_run <= 0;
            end
            if ((!rd_n || !cs_n) && adc_busy) busy_viol <= busy_viol + 1;
            if (adc_rst) rst_run <= rst_run + 1;
            else if (rst_run != 0) begin last_rst_run <= rst_run; rst_run <= 0; end
            if (cfg_ack) ack_cnt <= ack_cnt + 1;
            if (data_vld && nvld < 64) begin
                got_data[nvld]  <= data_out;
                got_sync[nvld]  <= sync;
                got_frame[nvld] <= frame;
                nvld <= nvld + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic cfg_write(input logic [15:0] w);
        @(negedge clk);
        cfg_wr_n = 1'b0;
        cfg_din  = w;
        @(negedge clk);
        chk(cfg_ack == 1'b1, "R2 ack", int'(cfg_ack), 1);
        cfg_wr_n = 1'b1;
        @(negedge clk);
        chk(cfg_ack == 1'b0, "R2 ack drop", int'(cfg_ack), 0);
    endtask

    task automatic check_words(input int n);
        for (int k = 0; k < n; k++) begin
            logic [15:0] exp;
            exp = {got_frame[k][7:0], 5'b10100, 3'(k % 8)};
            chk(got_data[k] == exp, "R7 word", int'(got_data[k]), int'(exp));
            chk(got_sync[k] == (k % 8 == 0), "R8 sync", int'(got_sync[k]), int'(k % 8 == 0));
            if (k > 0)
                chk(got_frame[k] == got_frame[k-1] + ((k % 8 == 0) ? 1 : 0),
                    "R7 frame order", got_frame[k], got_frame[k-1]);
        end
    endtask

    task automatic check_timing(input string tag);
        chk(last_conv_run == 2, {"R4 conv width ", tag}, last_conv_run, 2);
        chk(rd_min == 3 && rd_max == 3, {"R6 rd width ", tag}, rd_max, 3);
        chk(gap_min == 2, {"R6 rd gap ", tag}, gap_min, 2);
        chk(busy_viol == 0, {"R5 read while busy ", tag}, busy_viol, 0);
        chk(cs_n && rd_n, {"R6 cs released ", tag}, int'({cs_n, rd_n}), 3);
    endtask

    // configuration vectors: word, expected {stdby, range_sel, os}
    localparam logic [15:0] VEC_W [4] = '{16'h0005, 16'h001B, 16'hFF8E, 16'h0010};
    localparam logic [4:0]  VEC_E [4] = '{5'b00101, 5'b11011, 5'b01110, 5'b10000};

    initial begin
        rst_n = 1'b0; cfg_wr_n = 1'b1; cfg_din = '0; clr = 1'b1;
        repeat (4) @(negedge clk);
        chk({conv_n, cs_n, rd_n} == 3'b111, "R1 strobes in reset", int'({conv_n, cs_n, rd_n}), 7);
        chk({data_vld, sync, cfg_ack, adc_rst} == 4'b0, "R1 flags in reset",
            int'({data_vld, sync, cfg_ack, adc_rst}), 0);
        rst_n = 1'b1;
        clr   = 1'b0;
        @(negedge clk);
        chk({conv_n, cs_n, rd_n} == 3'b111, "R1 strobes after reset", int'({conv_n, cs_n, rd_n}), 7);
        chk({stdby, range_sel, os} == 5'b0, "R1 pins after reset", int'({stdby, range_sel, os}), 0);

        // vector table
        clear_mon();
        for (int i = 0; i < 4; i++) begin
            cfg_write(VEC_W[i]);
            chk({stdby, range_sel, os} == VEC_E[i], "R2 pins",
                int'({stdby, range_sel, os}), int'(VEC_E[i]));
        end
        chk(conv_falls == 0, "R4 no conversion without enable", conv_falls, 0);

        // strobe held low: one acknowledge
        clear_mon();
        @(negedge clk); cfg_wr_n = 1'b0; cfg_din = 16'h0003;
        repeat (4) @(negedge clk);
        cfg_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ack_cnt == 1, "R2 single ack", ack_cnt, 1);
        chk(os == 3'd3, "R2 os", int'(os), 3);

        // reset request pulse
        clear_mon();
        cfg_write(16'h0020);
        repeat (8) @(negedge clk);
        chk(last_rst_run == 4, "R3 reset width", last_rst_run, 4);
        chk(adc_rst == 1'b0, "R3 reset not kept", int'(adc_rst), 0);
        chk(os == 3'd0, "R3 other fields", int'(os), 0);

        // single frame
        clear_mon();
        busy_len = 6;
        cfg_write(16'h0040);
        cfg_write(16'h0000);
        repeat (200) @(negedge clk);
        chk(conv_falls == 1, "R9 stop after frame", conv_falls, 1);
        chk(nvld == 8, "R7 word count", nvld, 8);
        check_words(8);
        check_timing("single");

        // several frames, busy shorter than the wait
        clear_mon();
        busy_len = 3;
        cfg_write(16'h0040);
        for (int t = 0; t < 2000 && conv_falls < 3; t++) @(negedge clk);
        cfg_write(16'h0000);
        repeat (300) @(negedge clk);
        chk(conv_falls >= 3, "R9 continuous frames", conv_falls, 3);
        chk(nvld == 8 * conv_falls, "R9 whole frames", nvld, 8 * conv_falls);
        check_words(nvld);
        check_timing("continuous");

        // long busy
        clear_mon();
        busy_len = 40;
        cfg_write(16'h0040);
        cfg_write(16'h0000);
        repeat (300) @(negedge clk);
        chk(nvld == 8, "R5 words after long busy", nvld, 8);
        check_words(8);
        check_timing("long busy");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule